// File: doc/BRIEF.md
# UART Multiprocessor Address Filter

This block sits behind a UART receiver that already delivers whole frames. Each frame arrives as a one-cycle strobe that carries eight data bits, a ninth bit and the sampled stop bit. The block decides whether the frame reaches the host. When the 9-bit mode is on, a frame whose ninth bit is 1 is an address frame. The block tests the received byte against a station address that a per-bit mask qualifies, and against a broadcast pattern derived from the same two registers. A match raises the receive flag, captures the byte and opens the station for the data frames that follow. Data frames that arrive while the station is closed are dropped.

The mask lets one station answer to a unique address, to group addresses that leave some bits free, and to a broadcast pattern. Both registers reset to zero. With zero registers every address frame is accepted, so software that never programs the filter sees plain receiver behaviour. A sticky framing-error flag records any frame that was received with a low stop bit.

Top module: `uart_mp_addr_filter`

## Requirements
- R1: After reset, addr_q, mask_q, rx_flag, rx_buf, rx_data_en and ferr are all 0.
- R2: A cycle with reg_we=1 loads reg_wdata into addr_q when reg_sel=0, or into mask_q when reg_sel=1. The new value is visible in the cycle after the write.
- R3: Given-address match: for every bit where mask_q is 1, the received byte must equal addr_q. Bits where mask_q is 0 are ignored.
- R4: Broadcast match: every bit that is 1 in (addr_q | mask_q) must be 1 in the received byte. All other bits are ignored, so a byte of 0xFF always matches.
- R5: In 9-bit mode (mode9=1), an address frame (frm_bit9=1) that matches by R3 or by R4 does three things: it sets rx_flag, loads the byte into rx_buf and sets rx_data_en. All three changes are seen in the next cycle.
- R6: An address frame that matches neither pattern leaves rx_flag, rx_buf and rx_data_en unchanged.
- R7: In 9-bit mode, a data frame (frm_bit9=0) sets rx_flag and loads rx_buf when rx_data_en=1. When rx_data_en=0, the data frame is discarded.
- R8: clr_rxen clears rx_data_en, and clr_rxflag clears rx_flag. If a frame is accepted in the same cycle, the acceptance wins.
- R9: In 8-bit mode (mode9=0), every frame sets rx_flag and loads rx_buf, whatever its ninth bit. rx_data_en is not changed.
- R10: A frame with frm_stop=0 sets ferr whether or not the frame matches. ferr stays set until clr_ferr is asserted. A new framing error in the same cycle as clr_ferr wins over the clear.
- R11: With addr_q=0 and mask_q=0, every address frame matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode9 | input | 1 | 1: 9-bit mode with address filtering; 0: 8-bit mode |
| frm_valid | input | 1 | One-cycle strobe: a received frame is present |
| frm_data | input | 8 | Received data byte |
| frm_bit9 | input | 1 | Received ninth bit (1 marks an address frame) |
| frm_stop | input | 1 | Sampled stop bit (0 is a framing error) |
| reg_we | input | 1 | Register write enable |
| reg_sel | input | 1 | Write target: 0 station address, 1 enable mask |
| reg_wdata | input | 8 | Register write data |
| clr_rxflag | input | 1 | Clears the receive flag |
| clr_rxen | input | 1 | Clears the data receive enable |
| clr_ferr | input | 1 | Clears the framing error flag |
| addr_q | output | 8 | Station address register |
| mask_q | output | 8 | Address enable mask register |
| rx_flag | output | 1 | Receive flag |
| rx_buf | output | 8 | Last accepted byte |
| rx_data_en | output | 1 | Data frames are being accepted |
| ferr | output | 1 | Sticky framing error flag |

## Verification
The bench sweeps the address/mask combinations in which the given and broadcast patterns disagree. It uses a byte that only the broadcast pattern accepts, a group address that leaves one bit free, and a single differing bit where the mask is set. A comparator that ignores the mask, or that builds the broadcast pattern wrongly, accepts or rejects the wrong frame.

The bench also covers the same-cycle collisions:
- a clear arriving with an accepted frame;
- a clear arriving with a new framing error.

A design with the wrong priority would lose a received byte or a stop-bit error. Two further cases are checked:
- data frames arriving while the station is closed, where a leaky gate would hand them to the host;
- 8-bit mode, where a filter left active would drop frames.

// File: rtl/uart_af_pkg.sv
package uart_af_pkg;
  typedef enum logic {
    SEL_ADDR = 1'b0,
    SEL_MASK = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/uart_af_regs.sv
module uart_af_regs
  import uart_af_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic          sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] addr_o,
  output logic [DW-1:0] mask_o
);
  logic [DW-1:0] addr_q, addr_d;
  logic [DW-1:0] mask_q, mask_d;
  logic          addr_en, mask_en;

  always_comb begin
    addr_en = we_i && (reg_sel_e'(sel_i) == SEL_ADDR);
    mask_en = we_i && (reg_sel_e'(sel_i) == SEL_MASK);
    addr_d  = wdata_i;
    mask_d  = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mask_q <= '0;
    end else begin
      if (addr_en) addr_q <= addr_d;
      if (mask_en) mask_q <= mask_d;
    end
  end

  assign addr_o = addr_q;
  assign mask_o = mask_q;

  AST_ADDR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !sel_i) |=> (addr_o == $past(wdata_i))); // R2
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_i && sel_i) |=> $stable(mask_o)); // R2
endmodule

// File: rtl/uart_af_match.sv
module uart_af_match #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] mask_i,
  input  logic [DW-1:0] data_i,
  output logic          hit_o
);
  logic [DW-1:0] given_ok;
  logic [DW-1:0] bcast_ok;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign given_ok[i] = !mask_i[i] || (data_i[i] == addr_i[i]);
    assign bcast_ok[i] = !(addr_i[i] || mask_i[i]) || data_i[i];
  end

  assign hit_o = (&given_ok) || (&bcast_ok);

  always_comb begin
    if (addr_i == '0 && mask_i == '0)
      AST_OPEN_WHEN_ZERO: assert (hit_o); // R11
    if (&data_i)
      AST_ALL_ONES_HITS: assert (hit_o); // R4
  end
endmodule

// File: rtl/uart_af_ctrl.sv
module uart_af_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode9_i,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  input  logic          bit9_i,
  input  logic          stop_i,
  input  logic          hit_i,
  input  logic          clr_flag_i,
  input  logic          clr_en_i,
  input  logic          clr_ferr_i,
  output logic          flag_o,
  output logic [DW-1:0] buf_o,
  output logic          en_o,
  output logic          ferr_o
);
  logic          flag_q, flag_d;
  logic          en_q, en_d;
  logic          ferr_q, ferr_d;
  logic [DW-1:0] buf_q;
  logic          take_addr, take_data, load;

  always_comb begin
    take_addr = valid_i && mode9_i && bit9_i && hit_i;
    take_data = valid_i && (mode9_i ? (!bit9_i && en_q) : 1'b1);
    load      = take_addr || take_data;
    flag_d    = load ? 1'b1 : (clr_flag_i ? 1'b0 : flag_q);
    en_d      = take_addr ? 1'b1 : (clr_en_i ? 1'b0 : en_q);
    ferr_d    = (valid_i && !stop_i) ? 1'b1 : (clr_ferr_i ? 1'b0 : ferr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      en_q   <= 1'b0;
      ferr_q <= 1'b0;
      buf_q  <= '0;
    end else begin
      flag_q <= flag_d;
      en_q   <= en_d;
      ferr_q <= ferr_d;
      if (load) buf_q <= data_i;
    end
  end

  assign flag_o = flag_q;
  assign buf_o  = buf_q;
  assign en_o   = en_q;
  assign ferr_o = ferr_q;

  AST_MATCH_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && mode9_i && bit9_i && hit_i) |=> (en_o && flag_o)); // R5
  AST_MISS_KEEPS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && mode9_i && bit9_i && !hit_i) |=> $stable(buf_o)); // R6
  AST_CLOSED_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && mode9_i && !bit9_i && !en_o) |=> $stable(buf_o)); // R7
  AST_FERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !stop_i) |=> ferr_o); // R10
  AST_FERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ferr_o && !clr_ferr_i) |=> ferr_o); // R10
  AST_BYTE8_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !mode9_i) |=> (flag_o && $stable(en_o))); // R9
endmodule

// File: rtl/uart_mp_addr_filter.sv
module uart_mp_addr_filter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode9,
  input  logic          frm_valid,
  input  logic [DW-1:0] frm_data,
  input  logic          frm_bit9,
  input  logic          frm_stop,
  input  logic          reg_we,
  input  logic          reg_sel,
  input  logic [DW-1:0] reg_wdata,
  input  logic          clr_rxflag,
  input  logic          clr_rxen,
  input  logic          clr_ferr,
  output logic [DW-1:0] addr_q,
  output logic [DW-1:0] mask_q,
  output logic          rx_flag,
  output logic [DW-1:0] rx_buf,
  output logic          rx_data_en,
  output logic          ferr
);
  logic [1:0] rst_sync;
  logic       rst_int_n;
  logic       hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  uart_af_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .we_i(reg_we), .sel_i(reg_sel),
    .wdata_i(reg_wdata), .addr_o(addr_q), .mask_o(mask_q)
  );

  uart_af_match #(.DW(DW)) u_match (
    .addr_i(addr_q), .mask_i(mask_q), .data_i(frm_data), .hit_o(hit)
  );

  uart_af_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .mode9_i(mode9), .valid_i(frm_valid),
    .data_i(frm_data), .bit9_i(frm_bit9), .stop_i(frm_stop), .hit_i(hit),
    .clr_flag_i(clr_rxflag), .clr_en_i(clr_rxen), .clr_ferr_i(clr_ferr),
    .flag_o(rx_flag), .buf_o(rx_buf), .en_o(rx_data_en), .ferr_o(ferr)
  );
endmodule

// File: tb/uart_mp_addr_filter_bench.sv
module uart_mp_addr_filter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode9 = 1'b0, frm_valid = 1'b0, frm_bit9 = 1'b0, frm_stop = 1'b1;
  logic [7:0] frm_data = '0, reg_wdata = '0;
  logic       reg_we = 1'b0, reg_sel = 1'b0;
  logic       clr_rxflag = 1'b0, clr_rxen = 1'b0, clr_ferr = 1'b0;
  logic [7:0] addr_q, mask_q, rx_buf;
  logic       rx_flag, rx_data_en, ferr;
  int         n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  uart_mp_addr_filter u_uart_mp_addr_filter (.*);

  // {addr, mask, byte, expected hit}
  localparam int NV = 10;
  localparam logic [24:0] VEC [NV] = '{
    {8'hE6, 8'hF9, 8'hE6, 1'b1},  // R3 unique
    {8'hE6, 8'hF9, 8'hE4, 1'b1},  // R3 bit1 free
    {8'hE6, 8'hF9, 8'hE7, 1'b0},  // R3 masked bit differs
    {8'hE6, 8'hF9, 8'h66, 1'b0},  // R3 top bit differs
    {8'hE6, 8'hF9, 8'hFF, 1'b1},  // R4 broadcast
    {8'hE3, 8'hFA, 8'hE4, 1'b0},  // R3 excluded station
    {8'hE3, 8'hFA, 8'hFB, 1'b1},  // R4 broadcast only
    {8'hE3, 8'hFA, 8'hF3, 1'b0},  // R4 bit3 missing
    {8'h00, 8'h00, 8'h5A, 1'b1},  // R11 open
    {8'h35, 8'h0F, 8'hA5, 1'b1}   // R3 upper free
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic clr_all();
    @(negedge clk); clr_rxflag = 1'b1; clr_rxen = 1'b1; clr_ferr = 1'b1;
    @(negedge clk); clr_rxflag = 1'b0; clr_rxen = 1'b0; clr_ferr = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input logic b9, input logic st);
    @(negedge clk); frm_valid = 1'b1; frm_data = d; frm_bit9 = b9; frm_stop = st;
    @(negedge clk); frm_valid = 1'b0; frm_stop = 1'b1;
  endtask

  initial begin : watchdog
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({addr_q, mask_q, rx_buf, rx_flag, rx_data_en, ferr} == '0, "R1",
          {addr_q, mask_q}, 0);

    // R2 register access
    wr(1'b0, 8'hA7);
    check(addr_q == 8'hA7 && mask_q == 8'h00, "R2", {addr_q, mask_q}, 16'hA700);
    wr(1'b1, 8'h3C);
    check(addr_q == 8'hA7 && mask_q == 8'h3C, "R2", {addr_q, mask_q}, 16'hA73C);

    mode9 = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [7:0] a, m, b, prev;
      logic e;
      {a, m, b, e} = VEC[i];
      wr(1'b0, a); wr(1'b1, m); clr_all();
      prev = rx_buf;
      send(b, 1'b1, 1'b1);
      if (e) check(rx_flag && rx_data_en && rx_buf == b, "R5", rx_buf, b);
      else   check(!rx_flag && !rx_data_en && rx_buf == prev, "R6", rx_buf, prev);
    end

    // R7 data gating
    wr(1'b0, 8'h12); wr(1'b1, 8'hFF); clr_all();
    send(8'h99, 1'b0, 1'b1);
    check(!rx_flag && rx_buf != 8'h99, "R7", rx_flag, 0);
    send(8'h12, 1'b1, 1'b1);
    clr_all();
    send(8'h77, 1'b0, 1'b1);
    check(!rx_flag && rx_buf == 8'h12, "R7", rx_buf, 8'h12);
    send(8'h12, 1'b1, 1'b1);
    @(negedge clk); clr_rxflag = 1'b1;
    @(negedge clk); clr_rxflag = 1'b0;
    send(8'h44, 1'b0, 1'b1);
    check(rx_flag && rx_buf == 8'h44 && rx_data_en, "R7", rx_buf, 8'h44);

    // R8 same-cycle priority
    @(negedge clk); frm_valid = 1'b1; frm_data = 8'h55; frm_bit9 = 1'b0; clr_rxflag = 1'b1;
    @(negedge clk); frm_valid = 1'b0; clr_rxflag = 1'b0;
    check(rx_flag && rx_buf == 8'h55, "R8", rx_flag, 1);
    @(negedge clk); frm_valid = 1'b1; frm_data = 8'h12; frm_bit9 = 1'b1; clr_rxen = 1'b1;
    @(negedge clk); frm_valid = 1'b0; clr_rxen = 1'b0;
    check(rx_data_en, "R8", rx_data_en, 1);
    @(negedge clk); clr_rxen = 1'b1;
    @(negedge clk); clr_rxen = 1'b0;
    check(!rx_data_en, "R8", rx_data_en, 0);

    // R9 8-bit mode
    mode9 = 1'b0; clr_all();
    send(8'hC3, 1'b1, 1'b1);
    check(rx_flag && rx_buf == 8'hC3 && !rx_data_en, "R9", rx_buf, 8'hC3);
    send(8'h3C, 1'b0, 1'b1);
    check(rx_buf == 8'h3C && !rx_data_en, "R9", rx_buf, 8'h3C);

    // R10 framing error
    mode9 = 1'b1; clr_all();
    send(8'h00, 1'b1, 1'b0);  // non-matching address, stop low
    check(ferr && !rx_flag, "R10", ferr, 1);
    repeat (3) @(negedge clk);
    check(ferr, "R10", ferr, 1);
    @(negedge clk); frm_valid = 1'b1; frm_stop = 1'b0; frm_bit9 = 1'b0; clr_ferr = 1'b1;
    @(negedge clk); frm_valid = 1'b0; frm_stop = 1'b1; clr_ferr = 1'b0;
    check(ferr, "R10", ferr, 1);
    @(negedge clk); clr_ferr = 1'b1;
    @(negedge clk); clr_ferr = 1'b0;
    check(!ferr, "R10", ferr, 0);

    // R1 again: reset mid-run clears everything
    send(8'h12, 1'b1, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    check({addr_q, mask_q, rx_buf, rx_flag, rx_data_en, ferr} == '0, "R1",
          {rx_buf, ferr}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    send(8'h81, 1'b1, 1'b1);
    check(rx_flag && rx_buf == 8'h81, "R11", rx_buf, 8'h81);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule